// File: doc/BRIEF.md
# Decimal-Step Phase Accumulator

This block is the phase generator of a direct digital synthesizer whose tuning word moves the output frequency in exact decimal steps (for example exactly 1 Hz per unit) rather than in steps of the clock divided by a power of two. The phase is held in three chained sections. The lowest one is a plain binary fraction that gives resolution finer than one step. The middle one counts modulo a non-power-of-two integer, `MID_MOD`. The highest one is a two-bit binary quadrant counter. Each clock the whole phase advances by the programmed increment. Carries ripple upward from one section to the next.

The tuning word is split into three fields that match the sections. A load strobe captures it. The two quadrant bits drive waveform folding: bit 1 is the sign and bit 0 is the slope. The middle-section value indexes a sine table whose depth is `MID_MOD`. A one-cycle pulse marks every completed cycle of the phase. A load whose middle field is not a legal residue is rejected and flagged.

Top module: `mixmod_phase_acc`

## Requirements
- R1: While `rst` is high at a clock edge, all phase sections, the stored increment, `wrap_o` and `load_err_o` are cleared. After reset, with no load, the phase stays at zero.
- R2: `mid_idx_o` is always in the range 0 to `MID_MOD`-1. A carry from the fraction section occurs when the fraction sum reaches 2^`FRAC_W`. The middle section adds its increment and that carry, and it subtracts `MID_MOD` and carries upward when the sum reaches `MID_MOD`.
- R3: Define the phase as `quad_o`·`MID_MOD`·2^`FRAC_W` + `mid_idx_o`·2^`FRAC_W` + fraction. Define the increment as `inc_top_i`·`MID_MOD`·2^`FRAC_W` + `inc_mid_i`·2^`FRAC_W` + `inc_frac_i`. Each clock the phase grows by the increment, modulo 4·`MID_MOD`·2^`FRAC_W`.
- R4: `wrap_o` is high for exactly the cycle after each clock edge at which the quadrant counter overflows past 3. Over N clocks from zero phase, the number of such cycles is floor(N·increment / (4·`MID_MOD`·2^`FRAC_W`)), including steps that wrap on consecutive clocks.
- R5: A valid increment captured at the edge where `load_i` is high is first added at the following edge. The edge that captures it still adds the previous increment, and the phase is not reset, so the phase stays continuous.
- R6: A load with `inc_mid_i` >= `MID_MOD` raises `load_err_o` for the one cycle after that edge. It leaves the stored increment unchanged. `load_err_o` is low after every other edge.
- R7: `quad_o` = floor(phase / (`MID_MOD`·2^`FRAC_W`)). Bit 1 gives the sign half of the cycle and bit 0 gives the slope within that half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Capture strobe for the increment fields |
| inc_top_i | input | 2 | Quadrant part of the increment |
| inc_mid_i | input | MID_W | Step part of the increment, must be below MID_MOD |
| inc_frac_i | input | FRAC_W | Sub-step binary fraction of the increment |
| quad_o | output | 2 | Quadrant: bit 1 sign, bit 0 slope |
| mid_idx_o | output | MID_W | Table index, 0 to MID_MOD-1 |
| wrap_o | output | 1 | One-cycle pulse per completed phase cycle |
| load_err_o | output | 1 | One-cycle flag for a rejected load |

## Verification
The bench drives increments with the fraction and middle fields at their maximum, so that both carries fire on the same clock. A middle stage that compared with greater-than instead of greater-or-equal would leave an index equal to the modulus and drift the phase, and the count of cycles would come out wrong. An increment one unit below a full cycle makes the pulse fire on almost every clock; a design that fired the pulse on a quadrant edge instead of on an overflow would report a wrong count. The bench also changes the increment mid-run and checks the exact end phase, which catches a design that resets the phase or applies a load one edge early. A rejected load must leave the earlier rate untouched, which the end phase shows.

// File: rtl/pacc_pkg.sv
`timescale 1ns/1ps
package pacc_pkg;

    localparam int QUAD_W = 2;

    // bit 1: sign half, bit 0: slope within the half
    typedef enum logic [QUAD_W-1:0] {
        Q_POS_RISE = 2'd0,
        Q_POS_FALL = 2'd1,
        Q_NEG_FALL = 2'd2,
        Q_NEG_RISE = 2'd3
    } quad_e;

    // carries rippling up the three sections in one clock
    typedef struct packed {
        logic frac_c;
        logic mid_c;
        logic top_c;
    } carry_t;

    function automatic bit is_pow2(input int v);
        return (v > 0) && ((v & (v - 1)) == 0);
    endfunction

endpackage

// File: rtl/pacc_bin_stage.sv
`timescale 1ns/1ps
// Plain binary phase section with carry in and carry out.
module pacc_bin_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] inc_i,
    input  logic         cin_i,
    output logic [W-1:0] val_o,
    output logic         cout_o
);
    logic [W:0] sum;

    always_comb begin
        sum    = {1'b0, val_o} + {1'b0, inc_i} + {{W{1'b0}}, cin_i};
        cout_o = sum[W];
    end

    always_ff @(posedge clk) begin
        if (rst) val_o <= '0;
        else     val_o <= sum[W-1:0];
    end
endmodule

// File: rtl/pacc_mod_stage.sv
`timescale 1ns/1ps
// Phase section counting modulo MOD; a power-of-two modulus needs no compare.
module pacc_mod_stage #(
    parameter int MOD = 1000,
    parameter int W   = $clog2(MOD)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] inc_i,
    input  logic         cin_i,
    output logic [W-1:0] val_o,
    output logic         cout_o
);
    localparam bit         POW2  = pacc_pkg::is_pow2(MOD);
    localparam logic [W:0] MOD_V = (W+1)'(MOD);

    logic [W:0]   raw;
    logic [W-1:0] nxt;

    always_comb raw = {1'b0, val_o} + {1'b0, inc_i} + {{W{1'b0}}, cin_i};

    generate
        if (POW2) begin : g_bin
            always_comb begin
                nxt    = raw[W-1:0];
                cout_o = raw[W];
            end
        end else begin : g_mod
            logic [W:0] red;
            always_comb begin
                red    = raw - MOD_V;
                cout_o = (raw >= MOD_V);
                nxt    = cout_o ? red[W-1:0] : raw[W-1:0];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) val_o <= '0;
        else     val_o <= nxt;
    end
endmodule

// File: rtl/pacc_inc_reg.sv
`timescale 1ns/1ps
// Holds the active increment; rejects a step field outside the modulus.
module pacc_inc_reg #(
    parameter int FRAC_W = 8,
    parameter int MOD    = 1000,
    parameter int MID_W  = $clog2(MOD)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [1:0]        top_i,
    input  logic [MID_W-1:0]  mid_i,
    input  logic [FRAC_W-1:0] frac_i,
    output logic [1:0]        top_o,
    output logic [MID_W-1:0]  mid_o,
    output logic [FRAC_W-1:0] frac_o,
    output logic              err_o
);
    localparam logic [MID_W:0] MOD_V = (MID_W+1)'(MOD);

    logic legal;
    always_comb legal = ({1'b0, mid_i} < MOD_V);

    always_ff @(posedge clk) begin
        if (rst) begin
            top_o  <= '0;
            mid_o  <= '0;
            frac_o <= '0;
            err_o  <= 1'b0;
        end else begin
            err_o <= load_i && !legal;
            if (load_i && legal) begin
                top_o  <= top_i;
                mid_o  <= mid_i;
                frac_o <= frac_i;
            end
        end
    end
endmodule

// File: rtl/mixmod_phase_acc.sv
`timescale 1ns/1ps
module mixmod_phase_acc #(
    parameter  int FRAC_W  = 8,
    parameter  int MID_MOD = 1000,
    localparam int MID_W   = $clog2(MID_MOD)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [1:0]        inc_top_i,
    input  logic [MID_W-1:0]  inc_mid_i,
    input  logic [FRAC_W-1:0] inc_frac_i,
    output logic [1:0]        quad_o,
    output logic [MID_W-1:0]  mid_idx_o,
    output logic              wrap_o,
    output logic              load_err_o
);
    import pacc_pkg::*;

    logic [1:0]        act_top;
    logic [MID_W-1:0]  act_mid;
    logic [FRAC_W-1:0] act_frac;
    logic [FRAC_W-1:0] frac_val;
    logic [QUAD_W-1:0] top_val;
    carry_t            cy;
    quad_e             quad_q;
    logic              wrap_q;

    pacc_inc_reg #(.FRAC_W(FRAC_W), .MOD(MID_MOD), .MID_W(MID_W)) u_inc (
        .clk(clk), .rst(rst), .load_i(load_i),
        .top_i(inc_top_i), .mid_i(inc_mid_i), .frac_i(inc_frac_i),
        .top_o(act_top), .mid_o(act_mid), .frac_o(act_frac),
        .err_o(load_err_o)
    );

    pacc_bin_stage #(.W(FRAC_W)) u_frac (
        .clk(clk), .rst(rst), .inc_i(act_frac), .cin_i(1'b0),
        .val_o(frac_val), .cout_o(cy.frac_c)
    );

    pacc_mod_stage #(.MOD(MID_MOD), .W(MID_W)) u_mid (
        .clk(clk), .rst(rst), .inc_i(act_mid), .cin_i(cy.frac_c),
        .val_o(mid_idx_o), .cout_o(cy.mid_c)
    );

    pacc_bin_stage #(.W(QUAD_W)) u_top (
        .clk(clk), .rst(rst), .inc_i(act_top), .cin_i(cy.mid_c),
        .val_o(top_val), .cout_o(cy.top_c)
    );

    always_ff @(posedge clk) begin
        if (rst) wrap_q <= 1'b0;
        else     wrap_q <= cy.top_c;
    end

    always_comb begin
        quad_q = quad_e'(top_val);
        quad_o = quad_q;
        wrap_o = wrap_q;
    end
endmodule

// File: rtl/mixmod_phase_acc_chk.sv
`timescale 1ns/1ps
module mixmod_phase_acc_chk #(
    parameter  int FRAC_W  = 8,
    parameter  int MID_MOD = 1000,
    localparam int MID_W   = $clog2(MID_MOD)
) (
    input logic              clk,
    input logic              rst,
    input logic              load_i,
    input logic [1:0]        inc_top_i,
    input logic [MID_W-1:0]  inc_mid_i,
    input logic [FRAC_W-1:0] inc_frac_i,
    input logic [1:0]        quad_o,
    input logic [MID_W-1:0]  mid_idx_o,
    input logic              wrap_o,
    input logic              load_err_o
);
    localparam logic [MID_W:0] MOD_V = (MID_W+1)'(MID_MOD);

    logic bad_load;
    always_comb bad_load = load_i && ({1'b0, inc_mid_i} >= MOD_V);

    AST_MID_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        {1'b0, mid_idx_o} < MOD_V);                                   // R2
    AST_BACKSTEP_WRAPS: assert property (@(posedge clk) disable iff (rst)
        (quad_o < $past(quad_o)) |-> wrap_o);                         // R4
    AST_WRAP_NOT_FORWARD: assert property (@(posedge clk) disable iff (rst)
        wrap_o |-> (quad_o <= $past(quad_o)));                        // R4
    AST_BAD_LOAD_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        bad_load |=> load_err_o);                                     // R6
    AST_NO_SPURIOUS_ERR: assert property (@(posedge clk) disable iff (rst)
        !bad_load |=> !load_err_o);                                   // R6
endmodule

bind mixmod_phase_acc mixmod_phase_acc_chk #(.FRAC_W(FRAC_W), .MID_MOD(MID_MOD)) u_chk (.*);

// File: tb/mixmod_phase_acc_tb.sv
`timescale 1ns/1ps
module mixmod_phase_acc_tb;
    localparam int     FW   = 8;
    localparam int     MOD  = 1000;
    localparam int     MW   = $clog2(MOD);
    localparam longint FR   = 64'd1 << FW;
    localparam longint QSZ  = MOD * FR;
    localparam longint PER  = 4 * QSZ;
    localparam int     NV   = 6;

    // vector table: increment fields and number of clocks
    localparam int V_TOP [NV] = '{0,   0,    0,    1,    3,   2};
    localparam int V_MID [NV] = '{500, 1,    0,    999,  999, 0};
    localparam int V_FRAC[NV] = '{0,   0,    1,    255,  255, 0};
    localparam int V_N   [NV] = '{2000, 3000, 1000, 1000, 500, 999};

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          load_i = 1'b0;
    logic [1:0]    inc_top_i = '0;
    logic [MW-1:0] inc_mid_i = '0;
    logic [FW-1:0] inc_frac_i = '0;
    logic [1:0]    quad_o;
    logic [MW-1:0] mid_idx_o;
    logic          wrap_o;
    logic          load_err_o;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #2 clk = ~clk;

    mixmod_phase_acc #(.FRAC_W(FW), .MID_MOD(MOD)) u_dut (.*);

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint incv(input int t, input int m, input int f);
        return longint'(t) * QSZ + longint'(m) * FR + longint'(f);
    endfunction

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run(input int n, output longint w);
        w = 0;
        repeat (n) begin
            @(posedge clk); #1;
            if (wrap_o) w++;
        end
    endtask

    task automatic do_load(input int t, input int m, input int f,
                           output longint w, output logic e);
        @(negedge clk);
        inc_top_i = t[1:0]; inc_mid_i = m[MW-1:0]; inc_frac_i = f[FW-1:0];
        load_i = 1'b1;
        @(posedge clk); #1;
        w = longint'(wrap_o);
        e = load_err_o;
        @(negedge clk);
        load_i = 1'b0;
    endtask

    // compare counted pulses and end phase with the closed form
    task automatic chk_phase(input string req, input longint tot, input longint w);
        longint ph;
        ph = tot % PER;
        chk({req, " wraps"}, w, tot / PER);
        chk({req, " quad (R7)"}, longint'(quad_o), ph / QSZ);
        chk({req, " index (R2)"}, longint'(mid_idx_o), (ph % QSZ) / FR);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog all-requirements actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        longint w, w2, tot, ia, ib;
        logic   e;

        // R1: reset state and idle phase
        do_reset();
        #1;
        chk("R1 quad", longint'(quad_o), 0);
        chk("R1 index", longint'(mid_idx_o), 0);
        chk("R1 wrap", longint'(wrap_o), 0);
        chk("R1 err", longint'(load_err_o), 0);
        run(10, w);
        chk_phase("R1 idle", 0, w);

        // R3/R4: table of increments, each from zero phase
        for (int i = 0; i < NV; i++) begin
            do_reset();
            do_load(V_TOP[i], V_MID[i], V_FRAC[i], w, e);
            run(V_N[i], w);
            tot = longint'(V_N[i]) * incv(V_TOP[i], V_MID[i], V_FRAC[i]);
            chk_phase($sformatf("R3 R4 vec%0d", i), tot, w);
        end

        // R5: change of increment mid-run, no phase reset
        do_reset();
        ia = incv(0, 300, 17);
        ib = incv(1, 7, 200);
        do_load(0, 300, 17, w, e);
        run(37, w);
        do_load(1, 7, 200, w2, e);
        w += w2;
        run(53, w2);
        w += w2;
        tot = 38 * ia + 53 * ib;
        chk_phase("R5 continuity", tot, w);

        // R6: rejected load keeps the old rate
        do_reset();
        ia = incv(0, 900, 0);
        do_load(0, 900, 0, w, e);
        chk("R6 good load err", longint'(e), 0);
        run(20, w);
        do_load(1, MOD, 0, w2, e);
        w += w2;
        chk("R6 err raised", longint'(e), 1);
        run(1, w2);
        w += w2;
        chk("R6 err one cycle", longint'(load_err_o), 0);
        run(29, w2);
        w += w2;
        tot = 51 * ia;
        chk_phase("R6 rate kept", tot, w);

        // R1: reset mid-run clears phase and stored increment
        do_reset();
        #1;
        chk("R1 mid-run quad", longint'(quad_o), 0);
        chk("R1 mid-run index", longint'(mid_idx_o), 0);
        run(15, w);
        chk_phase("R1 increment cleared", 0, w);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule